// File: doc/BRIEF.md
# Trigger Buffer Occupancy Throttle

This block keeps a running count of how full the event buffers of a front-end readout chip are. Trigger accepts are throttled from this count before the chip's buffers can overflow. Every trigger accept adds a number of buffer units to the count. That number depends on the chip's sampling mode: three units in deconvolution mode and one unit in peak mode. An internal readout timer models the fixed time the chip needs to send out one event. Each time the timer completes, the count drops by one event's worth of units.

The count drives a status code for the trigger controller, which has four values: ready, warn, busy and error. The warn and busy levels are programmable inputs. The status is registered from the same next-count value that loads the counter, so it changes on the same clock edge as the count. The control loop back to the trigger source has a delay, so triggers can still arrive while busy is shown. These triggers are counted like any other. If the count ever goes above the configured capacity, a sticky error is raised.

A synchronous clear input models the chip reset. It empties the count, restarts the readout timer and clears the error.

Top module: `occ_throttle`

## Requirements
- R1: While `rstN` is low, or on the clock edge where `chipReset` is high, `occupancy` becomes 0 and `status` becomes READY (4'b0001). A trigger in that same cycle is ignored.
- R2: A trigger accept adds 3 to `occupancy` when `modeDeconv` is 1 and adds 1 when it is 0.
- R3: `status` is one-hot. READY is 4'b0001 when the count is below `warnLevel`. WARN is 4'b0010 when the count is at or above `warnLevel` and below `busyLevel`. BUSY is 4'b0100 when the count is at or above `busyLevel`. ERROR is 4'b1000.
- R4: `occupancy` and `status` both take their new values on the first rising clock edge at which the trigger is sampled.
- R5: While `occupancy` is nonzero, the readout timer completes one frame every FRAME_CLKS clocks. Each completion removes one step of units (3 or 1, set by the mode, and never more than the current count). The first completion lands FRAME_CLKS edges after the edge that made the count nonzero.
- R6: Triggers that arrive while BUSY is shown are still added to `occupancy`.
- R7: If a trigger and a frame completion fall in the same cycle, the net change is applied. With the mode held constant, the count stays the same.
- R8: A count above CAPACITY (default 30) sets ERROR. ERROR stays until `chipReset` or `rstN`, even after the count drains.
- R9: When a frame completion takes the count below `busyLevel`, `status` drops from BUSY to WARN on that same edge. The next trigger that brings the count back to `busyLevel` shows BUSY again on its own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipReset | input | 1 | Synchronous clear of the modelled chip buffers |
| trigAccept | input | 1 | One-cycle trigger accept pulse |
| modeDeconv | input | 1 | 1 = deconvolution mode (3 units per trigger), 0 = peak mode (1 unit) |
| warnLevel | input | CNT_W (6) | Count at which WARN starts |
| busyLevel | input | CNT_W (6) | Count at which BUSY starts |
| status | output | 4 | One-hot status: READY, WARN, BUSY, ERROR |
| occupancy | output | CNT_W (6) | Current buffer occupancy in units |

## Verification
If the internal count is wrong, it shows on `occupancy` at the very edge that samples the trigger or the completion. A wrong status level follows on that same edge, because the status is registered from the same next value. A readout timer that runs fast or slow shows up as a count drop one or more cycles off the FRAME_CLKS mark. A lost error flag shows up as a return to BUSY or WARN once the count drains after an overflow.

// File: rtl/occ_throttle_pkg.sv
package occ_throttle_pkg;

  typedef enum logic [3:0] {
    ST_READY = 4'b0001,
    ST_WARN  = 4'b0010,
    ST_BUSY  = 4'b0100,
    ST_ERROR = 4'b1000
  } thrStatus_e;

  typedef struct packed {
    logic clear;
    logic incr;
    logic decr;
  } cntStrobe_t;

endpackage

// File: rtl/occ_datapath.sv
module occ_datapath
  import occ_throttle_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int FRAME_CLKS = 280
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] stepIn,
  output logic [CNT_W-1:0] occQ,
  output logic [CNT_W-1:0] occNext,
  output logic             frameDone
);

  localparam int TMR_W = (FRAME_CLKS > 1) ? $clog2(FRAME_CLKS) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(FRAME_CLKS - 1);
  localparam logic [CNT_W:0]   SAT_MAX  = {1'b0, {CNT_W{1'b1}}};

  logic [TMR_W-1:0] tmrQ;
  logic [CNT_W:0]   sumWide;
  logic [CNT_W:0]   decAmt;
  logic [CNT_W:0]   resWide;

  // a frame finishes only while there is something buffered
  assign frameDone = (occQ != '0) && (tmrQ == TMR_LAST);

  always_comb begin
    sumWide = {1'b0, occQ} + (strobe.incr ? {1'b0, stepIn} : '0);
    decAmt  = '0;
    if (strobe.decr) begin
      decAmt = (occQ < stepIn) ? {1'b0, occQ} : {1'b0, stepIn};
    end
    resWide = sumWide - decAmt;
    if (strobe.clear) begin
      occNext = '0;
    end else if (resWide > SAT_MAX) begin
      occNext = {CNT_W{1'b1}};
    end else begin
      occNext = resWide[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occQ <= '0;
    end else begin
      occQ <= occNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrQ <= '0;
    end else if (strobe.clear || occQ == '0 || frameDone) begin
      tmrQ <= '0;
    end else begin
      tmrQ <= tmrQ + 1'b1;
    end
  end

endmodule

// File: rtl/throttle_ctrl.sv
module throttle_ctrl
  import occ_throttle_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int CAPACITY    = 30,
  parameter int DECONV_STEP = 3,
  parameter int PEAK_STEP   = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipReset,
  input  logic             trigAccept,
  input  logic             modeDeconv,
  input  logic             frameDone,
  input  logic [CNT_W-1:0] occNext,
  input  logic [CNT_W-1:0] warnLevel,
  input  logic [CNT_W-1:0] busyLevel,
  output cntStrobe_t       strobe,
  output logic [CNT_W-1:0] stepOut,
  output thrStatus_e       statusQ
);

  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);
  localparam logic [CNT_W-1:0] DSTEP = CNT_W'(DECONV_STEP);
  localparam logic [CNT_W-1:0] PSTEP = CNT_W'(PEAK_STEP);

  logic       errQ;
  logic       errNext;
  thrStatus_e statusNext;

  assign stepOut = modeDeconv ? DSTEP : PSTEP;

  always_comb begin
    strobe.clear = chipReset;
    strobe.incr  = trigAccept && !chipReset;
    strobe.decr  = frameDone && !chipReset;
  end

  always_comb begin
    errNext = !chipReset && (errQ || (occNext > CAP_V));
    if (errNext) begin
      statusNext = ST_ERROR;
    end else if (occNext >= busyLevel) begin
      statusNext = ST_BUSY;
    end else if (occNext >= warnLevel) begin
      statusNext = ST_WARN;
    end else begin
      statusNext = ST_READY;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ    <= 1'b0;
      statusQ <= ST_READY;
    end else begin
      errQ    <= errNext;
      statusQ <= statusNext;
    end
  end

endmodule

// File: rtl/occ_throttle.sv
module occ_throttle
  import occ_throttle_pkg::*;
#(
  parameter int  CAPACITY    = 30,
  parameter int  FRAME_CLKS  = 280,
  parameter int  DECONV_STEP = 3,
  parameter int  PEAK_STEP   = 1,
  localparam int CNT_W       = $clog2(CAPACITY + 1) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipReset,
  input  logic             trigAccept,
  input  logic             modeDeconv,
  input  logic [CNT_W-1:0] warnLevel,
  input  logic [CNT_W-1:0] busyLevel,
  output logic [3:0]       status,
  output logic [CNT_W-1:0] occupancy
);

  cntStrobe_t       strobe;
  logic [CNT_W-1:0] stepVal;
  logic [CNT_W-1:0] occNext;
  logic             frameDone;
  thrStatus_e       statusQ;

  throttle_ctrl #(
    .CNT_W(CNT_W), .CAPACITY(CAPACITY),
    .DECONV_STEP(DECONV_STEP), .PEAK_STEP(PEAK_STEP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chipReset(chipReset), .trigAccept(trigAccept),
    .modeDeconv(modeDeconv), .frameDone(frameDone), .occNext(occNext),
    .warnLevel(warnLevel), .busyLevel(busyLevel),
    .strobe(strobe), .stepOut(stepVal), .statusQ(statusQ)
  );

  occ_datapath #(
    .CNT_W(CNT_W), .FRAME_CLKS(FRAME_CLKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepIn(stepVal),
    .occQ(occupancy), .occNext(occNext), .frameDone(frameDone)
  );

  assign status = statusQ;

endmodule

// File: rtl/occ_throttle_chk.sv
module occ_throttle_chk #(
  parameter int CNT_W       = 6,
  parameter int DECONV_STEP = 3,
  parameter int PEAK_STEP   = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             chipReset,
  input logic             trigAccept,
  input logic             modeDeconv,
  input logic             frameDone,
  input logic [3:0]       status,
  input logic [CNT_W-1:0] occupancy
);

  localparam logic [CNT_W-1:0] DSTEP = CNT_W'(DECONV_STEP);
  localparam logic [CNT_W-1:0] PSTEP = CNT_W'(PEAK_STEP);
  localparam logic [CNT_W-1:0] MAXV  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] stepNow;
  assign stepNow = modeDeconv ? DSTEP : PSTEP;

  a_r1_clear: assert property (@(posedge clk) disable iff (!rstN)
    chipReset |=> (occupancy == '0 && status == 4'b0001));

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(status) == 1);

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (trigAccept && !chipReset && !frameDone && occupancy <= MAXV - stepNow)
    |=> occupancy == $past(occupancy) + $past(stepNow));

  a_r5_drain: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !trigAccept && !chipReset) |=> occupancy < $past(occupancy));

  a_r7_net: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && trigAccept && !chipReset && occupancy >= stepNow)
    |=> $stable(occupancy));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (status == 4'b1000 && !chipReset) |=> status == 4'b1000);

endmodule

bind occ_throttle occ_throttle_chk #(
  .CNT_W(CNT_W), .DECONV_STEP(DECONV_STEP), .PEAK_STEP(PEAK_STEP)
) u_chk (
  .clk(clk), .rstN(rstN), .chipReset(chipReset), .trigAccept(trigAccept),
  .modeDeconv(modeDeconv), .frameDone(frameDone), .status(status),
  .occupancy(occupancy)
);

// File: tb/test_occ_throttle.sv
module test_occ_throttle;

  localparam int CLK_PERIOD = 25;
  localparam int CNT_W      = 6;
  localparam int FRAME      = 280;
  localparam logic [3:0] S_READY = 4'b0001;
  localparam logic [3:0] S_WARN  = 4'b0010;
  localparam logic [3:0] S_BUSY  = 4'b0100;
  localparam logic [3:0] S_ERROR = 4'b1000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             chipReset = 1'b0;
  logic             trigAccept = 1'b0;
  logic             modeDeconv = 1'b1;
  logic [CNT_W-1:0] warnLevel = 6'd18;
  logic [CNT_W-1:0] busyLevel = 6'd27;
  logic [3:0]       status;
  logic [CNT_W-1:0] occupancy;

  int  nTests = 0;
  int  nFail  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  occ_throttle i_occ_throttle (
    .clk(clk), .rstN(rstN), .chipReset(chipReset), .trigAccept(trigAccept),
    .modeDeconv(modeDeconv), .warnLevel(warnLevel), .busyLevel(busyLevel),
    .status(status), .occupancy(occupancy)
  );

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic trig_once();
    trigAccept = 1'b1;
    @(negedge clk);
    trigAccept = 1'b0;
  endtask

  task automatic trig_spaced();
    trig_once();
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_chip();
    chipReset = 1'b1;
    trigAccept = 1'b1;
    @(negedge clk);
    chipReset = 1'b0;
    trigAccept = 1'b0;
  endtask

  task automatic wait_change(input int from);
    for (int i = 0; i < 400; i++) begin
      if (occupancy != CNT_W'(from)) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 reset occupancy", occupancy, 0);
    check("R1 reset status", status, S_READY);
  endtask

  task automatic t_peak();
    modeDeconv = 1'b0; warnLevel = 6'd2; busyLevel = 6'd4;
    trig_once();
    check("R2 peak step occupancy", occupancy, 1);
    check("R4 status on trigger edge", status, S_READY);
    repeat (2) @(negedge clk);
    trig_once();
    check("R3 warn level", status, S_WARN);
    repeat (2) @(negedge clk);
    trig_spaced();
    trig_once();
    check("R2 peak four triggers", occupancy, 4);
    check("R3 busy level", status, S_BUSY);
    clear_chip();
    check("R1 clear occupancy with trigger ignored", occupancy, 0);
    check("R1 clear status", status, S_READY);
  endtask

  task automatic t_readout();
    modeDeconv = 1'b1; warnLevel = 6'd18; busyLevel = 6'd27;
    trig_once();
    check("R2 deconv step", occupancy, 3);
    repeat (FRAME - 1) @(negedge clk);
    check("R5 before frame end", occupancy, 3);
    @(negedge clk);
    check("R5 frame end drain", occupancy, 0);
  endtask

  task automatic t_net();
    clear_chip();
    trig_once();
    repeat (FRAME - 1) @(negedge clk);
    trig_once();
    check("R7 net trigger and frame", occupancy, 3);
    clear_chip();
  endtask

  task automatic t_busy_error();
    for (int k = 0; k < 9; k++) trig_spaced();
    check("R3 busy at 27", status, S_BUSY);
    wait_change(27);
    check("R9 drop count", occupancy, 24);
    check("R9 busy to warn", status, S_WARN);
    trig_once();
    check("R9 rebusy on trigger", status, S_BUSY);
    repeat (2) @(negedge clk);
    trig_once();
    check("R6 counted while busy", occupancy, 30);
    check("R6 still busy at capacity", status, S_BUSY);
    repeat (2) @(negedge clk);
    trig_once();
    check("R8 overflow count", occupancy, 33);
    check("R8 error raised", status, S_ERROR);
    wait_change(33);
    check("R8 drained count", occupancy, 30);
    check("R8 error sticky", status, S_ERROR);
    clear_chip();
    check("R1 clear after error", status, S_READY);
    check("R1 clear count after error", occupancy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_peak();
    t_readout();
    t_net();
    t_busy_error();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule